// File: doc/BRIEF.md
# UART Transceiver with Status Flags and Interrupt Request

This block is an 8-bit asynchronous serial transceiver. It has a transmit holding register in front of a transmit shifter and a receive data register behind a receive sampler. An external baud generator supplies a 16x oversampling tick. Software reaches the block through a small register bus with four addresses, selected by `bus_addr`:

- 0: writes load the transmit holding register, reads return the received byte.
- 1: status, read only.
- 2: control, read and write.
- 3: any write clears the three receive error flags.

The block keeps six flags. Transmit-empty and transmit-complete describe the transmitter. Receive-full, parity error, overrun error and framing error describe the receiver. Three enable bits gate these flags onto one registered, level-sensitive interrupt line. Transmit-empty and transmit-complete each have their own enable. A single receive enable covers all four receive-side flags. Every receive-side flag is updated at the mid-bit sample of the stop bit, never earlier in the frame.

Top module: `uart_flagged_xcvr`

## Requirements
- R1: After reset the status register (address 1) reads 0x01. The status bits are: bit0 tx-empty, bit1 tx-complete, bit2 rx-full, bit3 parity error, bit4 overrun, bit5 framing error. After reset `irq` is low and `txd` is high.
- R2: A transmitted frame is one low start bit, 8 data bits LSB first, a parity bit when control bit0 is 1, and one high stop bit. Each bit lasts 16 ticks. The parity bit gives even parity over data plus parity bit when control bit1 is 0, and odd parity when it is 1.
- R3: A write to address 0 clears tx-empty in the next cycle. tx-empty returns to 1 once the held byte moves into an idle shifter. It stays 0 while the shifter is busy.
- R4: A write to address 0 clears tx-complete. tx-complete is set only when a stop bit ends with the holding register empty. It stays 0 between back-to-back frames.
- R5: A frame whose stop bit samples high sets rx-full and makes its byte readable at address 0. A read of address 0 clears rx-full.
- R6: The rx-full, parity, overrun and framing flags do not change before the stop bit's mid-bit sample.
- R7: With parity enabled, a received parity bit that does not match the selected parity sets the parity error flag.
- R8: A stop bit sampled low sets the framing error flag. That frame's byte is not stored.
- R9: A frame that completes while rx-full is set sets the overrun flag. The earlier byte is kept and the new byte is discarded.
- R10: A write to address 3 clears the parity, overrun and framing flags. It leaves rx-full unchanged.
- R11: `irq` is a register that takes the OR of three terms, one cycle after they change: tx-empty AND control bit2, tx-complete AND control bit3, and (rx-full OR any error) AND control bit4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Oversampling tick, 16 per bit |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at address 0) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Level interrupt request |

## Verification
A table of received frames is replayed with the following cases:
- parity off;
- even and odd parity with a good parity bit;
- a corrupted parity bit;
- a low stop bit;
- a corrupted parity bit together with a low stop bit.

These cases separate the parity path from the framing path and show that both can be flagged in the same frame. The table walk also checks that no flag moves before the stop sample. Each byte is also sent back out and captured bit by bit, with and without parity, so that bit order and parity sense are both pinned.

The following patterns isolate the remaining behaviours:
- two frames with no read in between, for overrun and for the old byte being kept;
- two back-to-back writes, which tell the empty event apart from the complete event;
- enable patterns that turn on one irq source at a time.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_ECLR = 2'd3
  } reg_addr_e;

  localparam int NFLAGS = 6;
  localparam int ST_TXE = 0;
  localparam int ST_TXC = 1;
  localparam int ST_RXF = 2;
  localparam int ST_PAR = 3;
  localparam int ST_OVR = 4;
  localparam int ST_FRM = 5;

  typedef struct packed {
    logic ie_rx;
    logic ie_txc;
    logic ie_txe;
    logic par_odd;
    logic par_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rx_state_e;

endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              busy,
  output logic              frame_end,
  output logic              txd
);
  localparam int CNT_W   = $clog2(OSR);
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  logic               busy_q, busy_n;
  logic               pen_q, pen_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [IDX_W-1:0]   idx_q, idx_n;
  logic [FRAME_W-1:0] frame_q, frame_n;
  logic [IDX_W-1:0]   last_idx;
  logic               par_bit;
  logic               bit_end;

  assign par_bit  = (^load_data) ^ par_odd;
  assign last_idx = pen_q ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
  assign bit_end  = busy_q && tick && (cnt_q == CNT_LAST);

  always_comb begin
    busy_n  = busy_q;
    pen_n   = pen_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    frame_n = frame_q;
    if (!busy_q) begin
      if (load) begin
        busy_n  = 1'b1;
        pen_n   = par_en;
        cnt_n   = '0;
        idx_n   = '0;
        frame_n = {1'b1, (par_en ? par_bit : 1'b1), load_data, 1'b0};
      end
    end else if (tick) begin
      if (cnt_q == CNT_LAST) begin
        cnt_n   = '0;
        frame_n = {1'b1, frame_q[FRAME_W-1:1]};
        if (idx_q == last_idx) begin
          busy_n = 1'b0;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      pen_q   <= 1'b0;
      cnt_q   <= '0;
      idx_q   <= '0;
      frame_q <= '1;
    end else begin
      busy_q  <= busy_n;
      pen_q   <= pen_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      frame_q <= frame_n;
    end
  end

  assign busy      = busy_q;
  assign frame_end = bit_end && (idx_q == last_idx);
  assign txd       = busy_q ? frame_q[0] : 1'b1;

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_bad,
  output logic              stop_bad
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OSR / 2 - 1);

  logic [1:0]        sync_q;
  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              pbit_q, pbit_n;
  logic              pen_q, pen_n;
  logic              pod_q, pod_n;
  logic              rx_s;
  logic [IDX_W-1:0]  last_idx;

  assign rx_s     = sync_q[1];
  assign last_idx = pen_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    data_n  = data_q;
    pbit_n  = pbit_q;
    pen_n   = pen_q;
    pod_n   = pod_q;
    case (state_q)
      RX_IDLE: begin
        if (tick && !rx_s) begin
          state_n = RX_START;
          cnt_n   = '0;
          pen_n   = par_en;
          pod_n   = par_odd;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == CNT_HALF) begin
            cnt_n   = '0;
            idx_n   = '0;
            state_n = rx_s ? RX_IDLE : RX_BITS;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_BITS: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_n = '0;
            if (idx_q < IDX_W'(DATA_W)) begin
              data_n = {rx_s, data_q[DATA_W-1:1]};
            end else begin
              pbit_n = rx_s;
            end
            idx_n = idx_q + 1'b1;
            if (idx_q == last_idx) begin
              state_n = RX_STOP;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          if (cnt_q == CNT_LAST) begin
            cnt_n   = '0;
            state_n = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      data_q  <= '0;
      pbit_q  <= 1'b0;
      pen_q   <= 1'b0;
      pod_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      state_q <= state_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      data_q  <= data_n;
      pbit_q  <= pbit_n;
      pen_q   <= pen_n;
      pod_q   <= pod_n;
    end
  end

  assign done     = (state_q == RX_STOP) && tick && (cnt_q == CNT_LAST);
  assign data     = data_q;
  assign stop_bad = !rx_s;
  assign par_bad  = pen_q && (((^data_q) ^ pbit_q) != pod_q);

endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_busy,
  input  logic              tx_frame_end,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_par_bad,
  input  logic              rx_stop_bad,
  output ctrl_t             ctrl,
  output logic [NFLAGS-1:0] status,
  output logic              irq
);
  logic              data_wr, data_rd, ctrl_wr, err_clr;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic              hfull_q, hfull_n;
  logic              txc_q, txc_n;
  logic [DATA_W-1:0] rxd_q, rxd_n;
  logic              rxf_q, rxf_n;
  logic              per_q, per_n;
  logic              ove_q, ove_n;
  logic              fre_q, fre_n;
  ctrl_t             ctrl_q, ctrl_n;
  logic              irq_q, irq_n;
  logic              rx_keep;
  logic [NFLAGS-1:0] en_vec;

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign err_clr = bus_wr && (bus_addr == ADDR_ECLR);
  assign tx_load = hfull_q && !tx_busy;
  assign rx_keep = rxf_q && !data_rd;

  always_comb begin
    hold_n  = data_wr ? bus_wdata : hold_q;
    hfull_n = data_wr ? 1'b1 : (tx_load ? 1'b0 : hfull_q);
    txc_n   = data_wr ? 1'b0 : ((tx_frame_end && !hfull_q) ? 1'b1 : txc_q);
    rxf_n   = rx_keep;
    rxd_n   = rxd_q;
    if (rx_done && !rx_stop_bad && !rx_keep) begin
      rxf_n = 1'b1;
      rxd_n = rx_byte;
    end
    per_n  = (per_q && !err_clr) || (rx_done && rx_par_bad);
    fre_n  = (fre_q && !err_clr) || (rx_done && rx_stop_bad);
    ove_n  = (ove_q && !err_clr) || (rx_done && rx_keep);
    ctrl_n = ctrl_wr ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
  end

  always_comb begin
    status         = '0;
    status[ST_TXE] = !hfull_q;
    status[ST_TXC] = txc_q;
    status[ST_RXF] = rxf_q;
    status[ST_PAR] = per_q;
    status[ST_OVR] = ove_q;
    status[ST_FRM] = fre_q;
    en_vec         = '0;
    en_vec[ST_TXE] = ctrl_q.ie_txe;
    en_vec[ST_TXC] = ctrl_q.ie_txc;
    en_vec[ST_RXF] = ctrl_q.ie_rx;
    en_vec[ST_PAR] = ctrl_q.ie_rx;
    en_vec[ST_OVR] = ctrl_q.ie_rx;
    en_vec[ST_FRM] = ctrl_q.ie_rx;
    irq_n          = |(status & en_vec);
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = rxd_q;
      ADDR_STAT: bus_rdata = DATA_W'(status);
      ADDR_CTRL: bus_rdata = DATA_W'(ctrl_q);
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hfull_q <= 1'b0;
      txc_q   <= 1'b0;
      rxd_q   <= '0;
      rxf_q   <= 1'b0;
      per_q   <= 1'b0;
      ove_q   <= 1'b0;
      fre_q   <= 1'b0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (data_wr) hold_q <= hold_n;
      if (rx_done) rxd_q <= rxd_n;
      if (ctrl_wr) ctrl_q <= ctrl_n;
      hfull_q <= hfull_n;
      txc_q   <= txc_n;
      rxf_q   <= rxf_n;
      per_q   <= per_n;
      ove_q   <= ove_n;
      fre_q   <= fre_n;
      irq_q   <= irq_n;
    end
  end

  assign tx_byte = hold_q;
  assign ctrl    = ctrl_q;
  assign irq     = irq_q;

endmodule

// File: rtl/uart_flagged_xcvr.sv
module uart_flagged_xcvr
  import uart_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              irq
);
  ctrl_t             ctrl_w;
  logic [NFLAGS-1:0] status_w;
  logic              tx_busy_w, tx_end_w, tx_load_w;
  logic [DATA_W-1:0] tx_byte_w, rx_byte_w;
  logic              rx_done_w, rx_par_bad_w, rx_stop_bad_w;

  uart_flag_bank #(.DATA_W(DATA_W)) i_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .tx_busy      (tx_busy_w),
    .tx_frame_end (tx_end_w),
    .tx_load      (tx_load_w),
    .tx_byte      (tx_byte_w),
    .rx_done      (rx_done_w),
    .rx_byte      (rx_byte_w),
    .rx_par_bad   (rx_par_bad_w),
    .rx_stop_bad  (rx_stop_bad_w),
    .ctrl         (ctrl_w),
    .status       (status_w),
    .irq          (irq)
  );

  uart_tx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_16x),
    .load      (tx_load_w),
    .load_data (tx_byte_w),
    .par_en    (ctrl_w.par_en),
    .par_odd   (ctrl_w.par_odd),
    .busy      (tx_busy_w),
    .frame_end (tx_end_w),
    .txd       (txd)
  );

  uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_16x),
    .rxd      (rxd),
    .par_en   (ctrl_w.par_en),
    .par_odd  (ctrl_w.par_odd),
    .done     (rx_done_w),
    .data     (rx_byte_w),
    .par_bad  (rx_par_bad_w),
    .stop_bad (rx_stop_bad_w)
  );

endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk
  import uart_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic              txd,
  input logic              irq,
  input logic [NFLAGS-1:0] status,
  input logic [CTRL_W-1:0] ctrl_bits,
  input logic              rx_done,
  input logic              tx_busy
);
  logic data_wr, data_rd, eclr_wr;
  logic [NFLAGS-1:0] en_vec;

  assign data_wr = bus_wr && (bus_addr == ADDR_DATA);
  assign data_rd = bus_rd && (bus_addr == ADDR_DATA);
  assign eclr_wr = bus_wr && (bus_addr == ADDR_ECLR);
  assign en_vec  = {{4{ctrl_bits[4]}}, ctrl_bits[3], ctrl_bits[2]};

  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  a_r3_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !status[ST_TXE]);
  a_r4_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !status[ST_TXC]);
  a_r4_done_after_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_TXC]) |-> ($past(tx_busy) && !tx_busy));
  a_r5_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rx_done) |=> !status[ST_RXF]);
  a_r6_full_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_RXF]) |-> $past(rx_done));
  a_r7_parity_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_PAR]) |-> $past(rx_done));
  a_r8_framing_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_FRM]) |-> $past(rx_done));
  a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[ST_OVR]) |-> $past(rx_done && status[ST_RXF]));
  a_r10_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (eclr_wr && !rx_done) |=> (status[ST_FRM:ST_PAR] == 3'b000));
  a_r11_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & en_vec))));

endmodule

bind uart_flagged_xcvr uart_flag_chk i_flag_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .txd       (txd),
  .irq       (irq),
  .status    (status_w),
  .ctrl_bits (ctrl_w),
  .rx_done   (rx_done_w),
  .tx_busy   (tx_busy_w)
);

// File: tb/test_uart_flagged_xcvr.sv
module test_uart_flagged_xcvr;
  localparam int DATA_W   = 8;
  localparam int OSR      = 16;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = TICK_DIV * OSR;
  localparam int NVEC     = 8;
  // {data, parity enable, odd parity, corrupt parity, low stop}
  localparam logic [11:0] VEC [NVEC] = '{
    {8'h55, 4'b0000}, {8'hA3, 4'b1000}, {8'h3C, 4'b1100}, {8'h81, 4'b1010},
    {8'hFF, 4'b1110}, {8'h00, 4'b0001}, {8'h7E, 4'b1011}, {8'hC9, 4'b0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rxd = 1'b1;
  logic txd, irq;
  int n_chk = 0, n_bad = 0, tdiv = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) begin
      tdiv <= 0; tick <= 1'b0;
    end else begin
      tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
      tick <= (tdiv == TICK_DIV - 1);
    end
  end

  uart_flagged_xcvr #(.DATA_W(DATA_W), .OSR(OSR)) i_uart_flagged_xcvr (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .rxd(rxd),
    .txd(txd), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 2'd1;
  endtask

  task automatic peek_status(output logic [5:0] s);
    addr = 2'd1; #1 s = rdata[5:0];
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk); addr = 2'd0; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = 2'd1;
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic pen, input logic podd,
                            input logic bpar, input logic bstop, input bit mid_chk);
    logic [5:0] s;
    rxd = 1'b0; wait_clks(BIT_CLKS);
    for (int b = 0; b < 8; b++) begin rxd = d[b]; wait_clks(BIT_CLKS); end
    if (pen) begin rxd = (^d) ^ podd ^ bpar; wait_clks(BIT_CLKS); end
    if (mid_chk) begin
      peek_status(s);
      check("R6 receive flags before stop sample", int'(s[5:2]), 0);
    end
    rxd = !bstop; wait_clks(BIT_CLKS);
    rxd = 1'b1; wait_clks(BIT_CLKS);
  endtask

  task automatic capture_tx(input int nbits, output logic [10:0] got);
    int guard = 0;
    got = '1;
    while (txd !== 1'b0 && guard < 4 * BIT_CLKS) begin @(negedge clk); guard++; end
    wait_clks(BIT_CLKS / 2);
    for (int b = 0; b < nbits; b++) begin
      got[b] = txd;
      if (b != nbits - 1) wait_clks(BIT_CLKS);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] s;
    logic [7:0] d, got_b;
    logic [10:0] got, exp_f;
    logic pen, podd, bpar, bstop;

    wait_clks(5); rst_n = 1'b1; @(negedge clk);
    peek_status(s);
    check("R1 reset status", int'(s), 6'h01);
    check("R1 reset irq", int'(irq), 0);
    check("R1 reset txd", int'(txd), 1);

    for (int i = 0; i < NVEC; i++) begin
      d = VEC[i][11:4]; pen = VEC[i][3]; podd = VEC[i][2];
      bpar = VEC[i][1]; bstop = VEC[i][0];
      bus_write(2'd2, {3'b000, 1'b1, 2'b00, podd, pen});
      send_frame(d, pen, podd, bpar, bstop, 1'b1);
      peek_status(s);
      check("R5 R7 R8 receive flags", int'(s[5:2]),
            int'({bstop, 1'b0, pen & bpar, !bstop}));
      check("R11 receive irq", int'(irq), 1);
      if (!bstop) begin
        pop(got_b);
        check("R5 received byte", int'(got_b), int'(d));
        peek_status(s);
        check("R5 read clears full", int'(s[2]), 0);
      end
      bus_write(2'd3, 8'h00);
      peek_status(s);
      check("R10 errors cleared", int'(s[5:2]), 0);
      @(negedge clk);
      check("R11 irq drops with flags", int'(irq), 0);

      bus_write(2'd0, d);
      peek_status(s);
      check("R3 write clears empty", int'(s[0]), 0);
      check("R4 write clears done", int'(s[1]), 0);
      @(negedge clk); peek_status(s);
      check("R3 empty once shifter loads", int'(s[0]), 1);
      capture_tx(pen ? 11 : 10, got);
      exp_f = pen ? {1'b1, (^d) ^ podd, d, 1'b0} : {2'b11, d, 1'b0};
      check("R2 transmitted frame", int'(got), int'(exp_f));
      wait_clks(BIT_CLKS); peek_status(s);
      check("R4 done after stop", int'(s[1]), 1);
    end

    // Overrun and error clear
    bus_write(2'd2, 8'h10);
    send_frame(8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    peek_status(s);
    check("R9 overrun with full kept", int'(s[5:2]), 4'b0101);
    bus_write(2'd3, 8'h00); peek_status(s);
    check("R10 clear keeps rx full", int'(s[5:2]), 4'b0001);
    pop(got_b);
    check("R9 older byte kept", int'(got_b), 8'h12);

    // Back-to-back transmit
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'hA5);
    bus_write(2'd0, 8'h5A);
    peek_status(s);
    check("R3 empty stays low while busy", int'(s[0]), 0);
    wait_clks(BIT_CLKS * 5); peek_status(s);
    check("R3 empty low mid first frame", int'(s[0]), 0);
    check("R4 done low mid first frame", int'(s[1]), 0);
    wait_clks(BIT_CLKS * 7); peek_status(s);
    check("R3 empty after second load", int'(s[0]), 1);
    check("R4 no done between frames", int'(s[1]), 0);
    wait_clks(BIT_CLKS * 10); peek_status(s);
    check("R4 done after last frame", int'(s[1]), 1);

    // Interrupt gating
    wait_clks(2);
    check("R11 irq off with enables clear", int'(irq), 0);
    bus_write(2'd2, 8'h04); wait_clks(2);
    check("R11 irq from tx empty", int'(irq), 1);
    bus_write(2'd2, 8'h08); wait_clks(2);
    check("R11 irq from tx done", int'(irq), 1);
    bus_write(2'd0, 8'h96); wait_clks(2);
    check("R11 irq drops when done clears", int'(irq), 0);
    wait_clks(BIT_CLKS * 11);
    check("R11 irq after transmission", int'(irq), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule